// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block drives the read data bus while an internally timed program or erase operation runs. A command decoder upstream sends a one-cycle start pulse with an operation code, a target address and a data word. From then on the block reports progress through ordinary reads, not through a separate status register. Bit 7 of every read word gives a polarity hint: for a word program it is the inverse of the bit being written, and for an erase it is 0. Bit 6 flips once for every new read strobe. The other bits pass the array data through unchanged.

A single down counter times each operation. Program and erase have separate lengths, both set by parameters; erase is much longer than program. When the counter expires, the busy flag drops and a one-cycle done pulse is issued in the same clock, together with the latched operation, address and data, so the array can commit the result. Start pulses are ignored while an operation is in progress and for a set number of cycles after reset. An asynchronous reset abandons any operation in flight, and no done pulse is issued for it.

Top module: `op_status_gen`

## Requirements
- R1: While a word program (op code 2'b00) is busy, bit 7 of `rd_data_o` is the inverse of bit 7 of the data latched at start. Bits 15..8 and 5..0 equal `array_data_i`.
- R2: While a sector erase (op code 2'b01) or a chip erase (op code 2'b10) is busy, bit 7 of `rd_data_o` is 0. Bits 15..8 and 5..0 equal `array_data_i`.
- R3: Bit 6 of `rd_data_o` while busy is a toggle bit. It inverts on the clock edge that first sees `rd_i` high after it was low, so a strobe held high for several cycles counts once. The toggle bit keeps its value while the block is idle. While idle, `rd_data_o` equals `array_data_i` exactly.
- R4: A start pulse that arrives while busy is ignored. The running operation keeps its length, and the done pulse carries the op code, address and data of the first operation.
- R5: An accepted program keeps `busy_o` high for exactly PROG_CYC cycles. In the clock where `busy_o` falls, `done_o` is high for one cycle, and `done_op_o`, `done_addr_o` and `done_data_o` show the latched values.
- R6: An accepted sector or chip erase keeps `busy_o` high for exactly ERASE_CYC cycles, then ends as in R5.
- R7: Driving `rst_ni` low clears `busy_o` and `done_o` at once. The aborted operation never produces a done pulse.
- R8: Start pulses are ignored during the first POR_CYC clock edges after reset is released.
- R9: The op code 2'b11 is reserved, and a start that carries it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle operation start from the command decoder |
| op_i | input | 2 | Operation code: 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| addr_i | input | ADDR_W | Target address |
| data_i | input | DATA_W | Program data |
| rd_i | input | 1 | Read strobe, active high |
| array_data_i | input | DATA_W | True array data at the read address |
| busy_o | output | 1 | Operation in progress |
| rd_data_o | output | DATA_W | Read word: status while busy, array data while idle |
| done_o | output | 1 | One-cycle commit pulse at completion |
| done_op_o | output | 2 | Op code of the completed operation |
| done_addr_o | output | ADDR_W | Address of the completed operation |
| done_data_o | output | DATA_W | Data of the completed operation |

## Verification
The assertions check the following on every cycle:
- the polarity of bit 7 during program and erase;
- idle passthrough;
- the toggle bit staying still while idle or while a strobe is held;
- the done pulse coinciding with the fall of busy;
- the latched operation staying frozen under repeated starts;
- the start-up block.

Other behaviours can only be shown by the bench scenarios, where a cycle-accurate reference model runs alongside the design:
- the exact program and erase lengths;
- the toggle sequence over a run of short and long reads;
- the values carried on the done outputs;
- the absence of a commit after a reset in mid-operation.

// File: rtl/op_status_pkg.sv
package op_status_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'b00,
    OP_SECT  = 2'b01,
    OP_CHIP  = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  function automatic logic is_erase(input logic [1:0] op);
    return (op == OP_SECT) || (op == OP_CHIP);
  endfunction
endpackage

// File: rtl/por_guard.sv
module por_guard #(
  parameter int unsigned POR_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(POR_CYC + 1) + 1;
  localparam logic [CW-1:0] POR_LEN = CW'(POR_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= POR_LEN;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);

  AST_POR_COUNTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
  AST_POR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R8
endmodule

// File: rtl/op_timer.sv
module op_timer #(
  parameter int unsigned PROG_CYC  = 12,
  parameter int unsigned ERASE_CYC = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic erase_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned MAX_CYC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CW        = $clog2(MAX_CYC + 1) + 1;
  localparam logic [CW-1:0] PROG_LEN  = CW'(PROG_CYC);
  localparam logic [CW-1:0] ERASE_LEN = CW'(ERASE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        if (cnt_q == CW'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (load_i) begin
        busy_o <= 1'b1;
        cnt_q  <= erase_i ? ERASE_LEN : PROG_LEN;
      end
    end
  end

  AST_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q != '0)); // R5
  AST_DONE_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R5
  AST_FALL_GIVES_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
endmodule

// File: rtl/toggle_gen.sv
module toggle_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic busy_i,
  output logic tog_o
);
  logic rd_q;
  logic rd_rise;

  assign rd_rise = rd_i && !rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      tog_o <= 1'b0;
    end else begin
      rd_q <= rd_i;
      if (busy_i && rd_rise) tog_o <= ~tog_o;
    end
  end

  AST_TOG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(tog_o)); // R3
  AST_TOG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_q) |=> $stable(tog_o)); // R3
endmodule

// File: rtl/status_mux.sv
module status_mux #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              busy_i,
  input  logic              erase_i,
  input  logic              data7_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign rd_data_o[b] = busy_i ? (!erase_i && !data7_i) : array_i[b];
    end else if (b == TOG_BIT) begin : g_tog
      assign rd_data_o[b] = busy_i ? tog_i : array_i[b];
    end else begin : g_pass
      assign rd_data_o[b] = array_i[b];
    end
  end

  always_comb begin
    if (busy_i && !erase_i)
      AST_PROG_POLL: assert (rd_data_o[POLL_BIT] != data7_i); // R1
    if (busy_i && erase_i)
      AST_ERASE_POLL: assert (rd_data_o[POLL_BIT] == 1'b0); // R2
    if (!busy_i)
      AST_IDLE_PASS: assert (rd_data_o == array_i); // R3
  end
endmodule

// File: rtl/op_status_gen.sv
module op_status_gen
  import op_status_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned PROG_CYC  = 12,
  parameter int unsigned ERASE_CYC = 60,
  parameter int unsigned POR_CYC   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o,
  output logic [1:0]        done_op_o,
  output logic [ADDR_W-1:0] done_addr_o,
  output logic [DATA_W-1:0] done_data_o
);
  logic              por_ready;
  logic              accept;
  logic              tog;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign accept = start_i && por_ready && !busy_o && (op_i != OP_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      op_q   <= op_i;
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  por_guard #(.POR_CYC(POR_CYC)) u_por (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_o (por_ready)
  );

  op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .erase_i (is_erase(op_i)),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  toggle_gen u_tog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_i),
    .busy_i (busy_o),
    .tog_o  (tog)
  );

  status_mux #(.DATA_W(DATA_W)) u_mux (
    .busy_i    (busy_o),
    .erase_i   (is_erase(op_q)),
    .data7_i   (data_q[7]),
    .tog_i     (tog),
    .array_i   (array_data_i),
    .rd_data_o (rd_data_o)
  );

  assign done_op_o   = op_q;
  assign done_addr_o = addr_q;
  assign done_data_o = data_q;

  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(data_q) && $stable(op_q) && $stable(addr_q))); // R4
  AST_POR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_ready && start_i) |=> !$rose(busy_o)); // R8
  AST_RSVD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && op_i == OP_RSVD) |=> !busy_o); // R9
  AST_OP_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (op_q != OP_RSVD)); // R9
endmodule

// File: tb/op_status_gen_test.sv
module op_status_gen_test;
  localparam int DW = 16, AW = 17, PROG = 12, ERASE = 60, POR = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd = 1'b0;
  logic [1:0] op = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0, arr = '0;
  logic busy, done;
  logic [DW-1:0] rdat, d_data;
  logic [1:0] d_op;
  logic [AW-1:0] d_addr;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  op_status_gen #(.DATA_W(DW), .ADDR_W(AW), .PROG_CYC(PROG), .ERASE_CYC(ERASE), .POR_CYC(POR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .addr_i(addr), .data_i(data),
    .rd_i(rd), .array_data_i(arr), .busy_o(busy), .rd_data_o(rdat), .done_o(done),
    .done_op_o(d_op), .done_addr_o(d_addr), .done_data_o(d_data));

  // reference model
  int m_por, m_cnt;
  bit m_busy, m_done, m_tog, m_rdq;
  logic [1:0] m_op;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;

  always @(posedge clk or negedge rst_n) begin : model
    bit rise, rdy;
    if (!rst_n) begin
      m_por = POR; m_cnt = 0; m_busy = 0; m_done = 0; m_tog = 0; m_rdq = 0;
    end else begin
      rise = rd && !m_rdq;
      rdy = (m_por == 0);
      if (m_busy && rise) m_tog = ~m_tog;
      m_rdq = rd;
      m_done = 0;
      if (m_por > 0) m_por--;
      if (m_busy) begin
        if (m_cnt == 1) begin m_busy = 0; m_done = 1; end
        else m_cnt--;
      end else if (start && rdy && op != 2'b11) begin
        m_busy = 1; m_cnt = (op == 2'b00) ? PROG : ERASE;
        m_op = op; m_addr = addr; m_data = data;
      end
    end
  end

  function automatic logic [DW-1:0] exp_rd();
    if (!m_busy) return arr;
    return {arr[15:8], (m_op == 2'b00) ? ~m_data[7] : 1'b0, m_tog, arr[5:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!finished) begin
      logic [DW-1:0] e;
      e = exp_rd();
      chk(busy === m_busy, (m_op == 2'b00) ? "R5 busy" : "R6 busy", 32'(busy), 32'(m_busy));
      chk(done === m_done, "R5 done", 32'(done), 32'(m_done));
      chk(rdat[6] === e[6], "R3 toggle", 32'(rdat), 32'(e));
      chk(rdat === e, m_busy ? ((m_op == 2'b00) ? "R1 read" : "R2 read") : "R3 idle read",
          32'(rdat), 32'(e));
      if (m_done) begin
        chk(d_data === m_data, "R4 done data", 32'(d_data), 32'(m_data));
        chk(d_addr === m_addr, "R4 done addr", 32'(d_addr), 32'(m_addr));
        chk(d_op === m_op, "R5 done op", 32'(d_op), 32'(m_op));
      end
    end
  end

  always @(negedge clk) arr <= 16'($urandom);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(input logic [1:0] o, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    start = 1'b1; op = o; addr = a; data = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic rdp(input int hold);
    @(negedge clk); rd = 1'b1;
    cyc(hold);
    rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    errors++;
    summary();
  end

  initial begin
    int n;
    cyc(3);
    chk(busy === 1'b0 && done === 1'b0, "R7 reset state", 32'({busy, done}), 32'd0);
    rst_n = 1'b1;
    // R8: start straight after reset is blocked
    go(2'b00, 17'h00123, 16'h0055);
    chk(busy === 1'b0, "R8 start during power-on wait", 32'(busy), 32'd0);
    cyc(POR + 2);
    // R1 R3: program with bit7 = 0, short and held reads
    go(2'b00, 17'h01234, 16'h1234);
    rdp(1); rdp(3); rdp(1);
    // R4: start while busy is ignored
    go(2'b01, 17'h1F000, 16'hFFFF);
    rdp(2);
    cyc(PROG);
    rdp(2);
    // R1: program with bit7 = 1
    go(2'b00, 17'h1ABCD, 16'h80F0);
    rdp(1); rdp(1);
    cyc(PROG);
    // R2 R6: sector erase with reads
    go(2'b01, 17'h03000, 16'h0000);
    rdp(1); rdp(4); rdp(1);
    cyc(ERASE);
    // R6: chip erase length measured
    go(2'b10, 17'h05555, 16'h0010);
    n = 0;
    while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
    chk(n == ERASE, "R6 erase length", 32'(n), 32'(ERASE));
    cyc(2);
    // R5: program length measured
    go(2'b00, 17'h00042, 16'h7E81);
    n = 0;
    while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
    chk(n == PROG, "R5 program length", 32'(n), 32'(PROG));
    // R9: reserved op ignored
    go(2'b11, 17'h00001, 16'h00FF);
    chk(busy === 1'b0, "R9 reserved op", 32'(busy), 32'd0);
    // R7: reset in mid-operation
    go(2'b00, 17'h00777, 16'h00AA);
    cyc(PROG / 2);
    rst_n = 1'b0;
    #1;
    chk(busy === 1'b0 && done === 1'b0, "R7 abort on reset", 32'({busy, done}), 32'd0);
    cyc(2);
    rst_n = 1'b1;
    cyc(PROG + 4);
    chk(busy === 1'b0, "R7 no resume after reset", 32'(busy), 32'd0);
    cyc(POR);
    // R3: idle reads leave data untouched
    rdp(1); rdp(2);
    summary();
  end
endmodule